// File: doc/BRIEF.md
# Linear Flash Read-Ahead Engine

This block performs linear reads from a serial NOR flash for a processor. Software loads a word-aligned start address and a length in 32-bit words, then writes a start bit. The engine asserts chip select and sends one read command followed by the address, with no dummy cycles. It then clocks data in and packs each group of four bytes into a little-endian word. Each word goes into a small FIFO. Software drains the FIFO by reading a data register, and polls a status register until the FIFO is empty and the session is no longer busy.

The address register covers the low 16 MB window. The top address byte comes from a separate register and is sent only in 4-byte addressing mode. A session never leaves its 16 MB window. When the low 24 bits roll over, the engine closes the flash transaction and reopens it at offset zero of the same window. When the FIFO is full, the serial clock is held low at the next word boundary, so no data is lost however slowly software reads.

Top module: `flash_readahead`

## Requirements
- R1: After reset, status (offset 0x04) reads 2: bit 0 is busy = 0 and bit 1 is FIFO empty = 1. The level register (0x18) reads 0 and the data register (0x08) reads 0.
- R2: Writing bit 0 = 1 to offset 0x00, with a nonzero word count, starts a session. The engine lowers `spi_cs_n` and sends the command byte from `cfg_cmd`, then the address, all MSB first, with no dummy bits.
  - With `cfg_addr4` = 0, the address is the 24 bits from the base register (0x0C), and the upper-byte register is not used.
  - With `cfg_addr4` = 1, the upper byte (register 0x14, bits [31:24]) is sent first.
  - Base bits [1:0] are treated as zero.
  - `spi_sck` is low whenever `spi_cs_n` is high.
- R3: Each word read from 0x08 carries the first flash byte of that word in bits [7:0] and the fourth in bits [31:24].
- R4: Each read of 0x08 while the FIFO holds data returns the oldest word and removes it. A read of 0x08 while the FIFO is empty returns 0 and leaves the level unchanged.
- R5: Busy stays 1 until the number of words written to 0x10 has been pushed. Then `spi_cs_n` returns high and busy falls. A read is complete when status reads 2.
- R6: When the FIFO is full at a word boundary, `spi_sck` stops and holds low until space frees. Every word still arrives, in order.
- R7: The low 24 address bits advance by 4 per word and wrap to 0 without changing the upper byte. On a wrap with words still to read, the engine raises `spi_cs_n` and sends a new command at offset 0 of the same window.
- R8: The level (0x18) gives the number of FIFO words. The done counter (0x1C) gives the words pushed in the current session. The current address (0x20) gives {upper byte if 4-byte mode else 0, next 24-bit address}.
- R9: A start write while busy, or with a word count of 0, does nothing: no flash command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data register) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| cfg_cmd | input | 8 | Flash read command byte |
| cfg_addr4 | input | 1 | 1 selects 4-byte addressing |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hardest situations to reach are the window wrap and the stall.

The wrap only appears when a session starts within a few words of the top of a 16 MB window. The bench therefore starts a 4-byte session at 0xFFFFF8 with a non-zero upper byte. It then checks that a second command carries that upper byte with zero low bits.

The stall needs software to fall behind the flash. The bench asks for more words than the FIFO holds and does not read for a long time. It then counts serial clock edges over an idle interval before draining and comparing every word with a behavioural flash model.

// File: rtl/fra_pkg.sv
package fra_pkg;
   localparam int LOW_AW = 24;
   localparam int HDR_W  = 40;

   localparam logic [5:0] OFS_CTRL   = 6'h00;
   localparam logic [5:0] OFS_STATUS = 6'h04;
   localparam logic [5:0] OFS_RDATA  = 6'h08;
   localparam logic [5:0] OFS_BASE   = 6'h0C;
   localparam logic [5:0] OFS_NWORDS = 6'h10;
   localparam logic [5:0] OFS_HIBYTE = 6'h14;
   localparam logic [5:0] OFS_LEVEL  = 6'h18;
   localparam logic [5:0] OFS_DONE   = 6'h1C;
   localparam logic [5:0] OFS_CURADR = 6'h20;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_HDR,
      SQ_DATA,
      SQ_GAP
   } sq_state_t;
endpackage

// File: rtl/fra_fifo.sv
module fra_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full,
   output logic [LVL_W-1:0] level
);
   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("fra_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;

   assign empty = (level == '0);
   assign full  = (level == LVL_W'(DEPTH));
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/fra_seq.sv
module fra_seq
   import fra_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [21:0]       base_word,
   input  logic [CNT_W-1:0]  word_cnt,
   input  logic [7:0]        upper,
   input  logic              addr4,
   input  logic [7:0]        cmd,
   input  logic              fifo_full,
   output logic              push,
   output logic [31:0]       push_data,
   output logic              busy,
   output logic [23:0]       cur_addr,
   output logic [7:0]        cur_upper,
   output logic [CNT_W-1:0]  words_done,
   output logic              sck,
   output logic              cs_n,
   output logic              mosi,
   input  logic              miso
);
   sq_state_t        st;
   logic [HDR_W-1:0] tx;
   logic [5:0]       bitcnt;
   logic             phase;
   logic [CNT_W-1:0] left;
   logic [31:0]      word, word_nx;
   logic [7:0]       cmd_q, upper_q;
   logic             addr4_q;
   logic [5:0]       hdr_last;
   logic             wrap;

   function automatic logic [HDR_W-1:0] mk_hdr(input logic [7:0] c, input logic [7:0] u,
                                              input logic [23:0] a, input logic four);
      return four ? {c, u, a} : {c, a, 8'h00};
   endfunction

   always_comb begin
      word_nx = word;
      word_nx[{bitcnt[4:3], ~bitcnt[2:0]}] = miso;
   end

   assign hdr_last  = addr4_q ? 6'd39 : 6'd31;
   assign push      = (st == SQ_DATA) && phase && (bitcnt == 6'd31);
   assign push_data = word_nx;
   assign busy      = (st != SQ_IDLE);
   assign mosi      = tx[HDR_W-1];
   assign wrap      = &cur_addr[23:2];
   assign cur_upper = addr4_q ? upper_q : 8'h00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= SQ_IDLE;
         tx         <= '0;
         bitcnt     <= '0;
         phase      <= 1'b0;
         left       <= '0;
         word       <= '0;
         cmd_q      <= '0;
         upper_q    <= '0;
         addr4_q    <= 1'b0;
         cur_addr   <= '0;
         words_done <= '0;
         sck        <= 1'b0;
         cs_n       <= 1'b1;
      end else begin
         case (st)
            SQ_IDLE: begin
               if (start && (word_cnt != '0)) begin
                  cur_addr   <= {base_word, 2'b00};
                  left       <= word_cnt;
                  words_done <= '0;
                  cmd_q      <= cmd;
                  upper_q    <= upper;
                  addr4_q    <= addr4;
                  tx         <= mk_hdr(cmd, upper, {base_word, 2'b00}, addr4);
                  bitcnt     <= '0;
                  phase      <= 1'b0;
                  word       <= '0;
                  cs_n       <= 1'b0;
                  st         <= SQ_HDR;
               end
            end
            SQ_HDR: begin
               if (!phase) begin
                  sck   <= 1'b1;
                  phase <= 1'b1;
               end else begin
                  sck   <= 1'b0;
                  phase <= 1'b0;
                  tx    <= {tx[HDR_W-2:0], 1'b0};
                  if (bitcnt == hdr_last) begin
                     bitcnt <= '0;
                     st     <= SQ_DATA;
                  end else begin
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
            end
            SQ_DATA: begin
               if (!phase) begin
                  if (!((bitcnt == '0) && fifo_full)) begin
                     sck   <= 1'b1;
                     phase <= 1'b1;
                  end
               end else begin
                  sck   <= 1'b0;
                  phase <= 1'b0;
                  word  <= push ? '0 : word_nx;
                  if (push) begin
                     bitcnt     <= '0;
                     left       <= left - 1'b1;
                     words_done <= words_done + 1'b1;
                     cur_addr   <= cur_addr + 24'd4;
                     if (left == CNT_W'(1)) begin
                        cs_n <= 1'b1;
                        st   <= SQ_IDLE;
                     end else if (wrap) begin
                        cs_n <= 1'b1;
                        st   <= SQ_GAP;
                     end
                  end else begin
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
            end
            default: begin
               tx     <= mk_hdr(cmd_q, upper_q, cur_addr, addr4_q);
               bitcnt <= '0;
               phase  <= 1'b0;
               cs_n   <= 1'b0;
               st     <= SQ_HDR;
            end
         endcase
      end
   end
endmodule

// File: rtl/flash_readahead.sv
module flash_readahead
   import fra_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CNT_W = 16,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [5:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic [7:0]  cfg_cmd,
   input  logic        cfg_addr4,
   output logic        spi_sck,
   output logic        spi_cs_n,
   output logic        spi_mosi,
   input  logic        spi_miso
);
   generate
      if ((CNT_W < 1) || (CNT_W > 32)) begin : g_bad_cnt
         $error("flash_readahead: CNT_W must lie in 1..32");
      end
   endgenerate

   logic [23:0]      base_q;
   logic [CNT_W-1:0] nwords_q;
   logic [7:0]       hibyte_q;
   logic             start, busy;
   logic             fifo_push, fifo_pop, fifo_empty, fifo_full;
   logic [31:0]      fifo_wdata, fifo_head;
   logic [LVL_W-1:0] fifo_level;
   logic [23:0]      cur_addr;
   logic [7:0]       cur_upper;
   logic [CNT_W-1:0] words_done;

   assign start    = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[0];
   assign fifo_pop = reg_rd && (reg_addr == OFS_RDATA) && !fifo_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         nwords_q <= '0;
         hibyte_q <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            OFS_BASE:   base_q   <= reg_wdata[23:0];
            OFS_NWORDS: nwords_q <= reg_wdata[CNT_W-1:0];
            OFS_HIBYTE: hibyte_q <= reg_wdata[31:24];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (reg_addr)
         OFS_STATUS: reg_rdata = {30'd0, fifo_empty, busy};
         OFS_RDATA:  reg_rdata = fifo_empty ? 32'd0 : fifo_head;
         OFS_BASE:   reg_rdata = {8'd0, base_q};
         OFS_NWORDS: reg_rdata = 32'(nwords_q);
         OFS_HIBYTE: reg_rdata = {hibyte_q, 24'd0};
         OFS_LEVEL:  reg_rdata = 32'(fifo_level);
         OFS_DONE:   reg_rdata = 32'(words_done);
         OFS_CURADR: reg_rdata = {cur_upper, cur_addr};
         default:    reg_rdata = 32'd0;
      endcase
   end

   fra_seq #(.CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .base_word  (base_q[23:2]),
      .word_cnt   (nwords_q),
      .upper      (hibyte_q),
      .addr4      (cfg_addr4),
      .cmd        (cfg_cmd),
      .fifo_full  (fifo_full),
      .push       (fifo_push),
      .push_data  (fifo_wdata),
      .busy       (busy),
      .cur_addr   (cur_addr),
      .cur_upper  (cur_upper),
      .words_done (words_done),
      .sck        (spi_sck),
      .cs_n       (spi_cs_n),
      .mosi       (spi_mosi),
      .miso       (spi_miso)
   );

   fra_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (fifo_push),
      .push_data (fifo_wdata),
      .pop       (fifo_pop),
      .head      (fifo_head),
      .empty     (fifo_empty),
      .full      (fifo_full),
      .level     (fifo_level)
   );
endmodule

// File: rtl/fra_chk.sv
module fra_chk #(
   parameter int DEPTH = 8,
   parameter int LVL_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             spi_cs_n,
   input logic             spi_sck,
   input logic             fifo_full,
   input logic             fifo_empty,
   input logic             fifo_push,
   input logic             fifo_pop,
   input logic [LVL_W-1:0] fifo_level
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !fifo_push); // R6
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> !fifo_pop); // R4
   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck); // R2
   AST_CS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> spi_cs_n); // R5
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= LVL_W'(DEPTH)); // R8
   AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_push && !fifo_pop) |=> (fifo_level == $past(fifo_level) + 1'b1)); // R8
endmodule

bind flash_readahead fra_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .spi_cs_n   (spi_cs_n),
   .spi_sck    (spi_sck),
   .fifo_full  (fifo_full),
   .fifo_empty (fifo_empty),
   .fifo_push  (fifo_push),
   .fifo_pop   (fifo_pop),
   .fifo_level (fifo_level)
);

// File: tb/flash_readahead_bench.sv
`timescale 1ns/1ps
module flash_readahead_bench;
   localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h04, A_DATA = 6'h08, A_BASE = 6'h0C,
                          A_NW = 6'h10, A_HI = 6'h14, A_LVL = 6'h18, A_DONE = 6'h1C,
                          A_CUR = 6'h20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [7:0]  cfg_cmd = 8'h03;
   logic        cfg_addr4 = 1'b0;
   logic        spi_sck, spi_cs_n, spi_mosi;
   logic        spi_miso = 1'b0;

   int nchk = 0, nfail = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   flash_readahead u_flash_readahead (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_cmd(cfg_cmd), .cfg_addr4(cfg_addr4),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

   function automatic logic [7:0] fbyte(input logic [31:0] a);
      return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ a[31:24] ^ 8'h5A;
   endfunction

   function automatic logic [31:0] expw(input logic [7:0] up, input logic [23:0] a);
      logic [31:0] b = {up, a};
      return {fbyte(b + 3), fbyte(b + 2), fbyte(b + 1), fbyte(b)};
   endfunction

   // behavioural flash: mode 0, samples on rising, shifts on falling
   int          f_bits = 0, f_dcnt = 0, f_abits;
   logic [39:0] f_in = '0;
   logic [31:0] f_addr = '0;
   logic [7:0]  f_byte;
   logic [7:0]  cmd_log[$];
   logic [31:0] addr_log[$];
   int          sck_edges = 0;

   assign f_abits = cfg_addr4 ? 40 : 32;

   always @(negedge spi_cs_n) begin
      f_bits = 0;
      f_dcnt = 0;
      f_in   = '0;
   end

   always @(posedge spi_sck) begin
      sck_edges++;
      if (!spi_cs_n && f_bits < f_abits) begin
         f_in = {f_in[38:0], spi_mosi};
         f_bits++;
         if (f_bits == f_abits) begin
            if (f_abits == 40) begin
               cmd_log.push_back(f_in[39:32]);
               f_addr = f_in[31:0];
            end else begin
               cmd_log.push_back(f_in[31:24]);
               f_addr = {8'h00, f_in[23:0]};
            end
            addr_log.push_back(f_addr);
         end
      end
   end

   always @(negedge spi_sck) begin
      if (!spi_cs_n && f_bits == f_abits) begin
         f_byte   = fbyte(f_addr + 32'(f_dcnt / 8));
         spi_miso = f_byte[7 - (f_dcnt % 8)];
         f_dcnt++;
      end
   end

   // per-clock comparison against the idle-bus rule
   always @(negedge clk) begin
      if (rst_n && spi_cs_n && spi_sck) begin
         nfail++;
         $display("FAIL R2 sck high while cs idle act=1 exp=0");
      end
   end

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 5000; i++) begin
         rd(A_STAT, s);
         if (!s[0]) break;
      end
   endtask

   task automatic drain(input int n, input logic [7:0] up, input logic [23:0] a0, input string rq);
      logic [31:0] s, d;
      for (int i = 0; i < n; i++) begin
         for (int k = 0; k < 500; k++) begin
            rd(A_STAT, s);
            if (!s[1]) break;
         end
         rd(A_DATA, d);
         check(rq, d, expw(up, 24'(a0 + 24'(4 * i))));
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog act=running exp=done");
      summary();
   end

   initial begin
      logic [31:0] v;
      int n0, e0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      rd(A_STAT, v); check("R1 status", v, 32'd2);
      rd(A_LVL, v);  check("R1 level", v, 32'd0);
      rd(A_DATA, v); check("R1 data", v, 32'd0);

      // R2/R3/R5/R8: 3-byte session, upper byte ignored, base bits[1:0] dropped
      cfg_cmd = 8'h03; cfg_addr4 = 1'b0;
      wr(A_HI, 32'h3700_0000);
      wr(A_BASE, 32'h0000_1237);
      wr(A_NW, 32'd5);
      wr(A_CTRL, 32'd1);
      rd(A_STAT, v); check("R5 busy after start", v[0], 1'b1);
      wait_idle();
      check("R2 one command", 32'(cmd_log.size()), 32'd1);
      check("R2 cmd byte", 32'(cmd_log[0]), 32'h03);
      check("R2 3-byte addr", addr_log[0], 32'h0000_1234);
      rd(A_LVL, v);  check("R8 level", v, 32'd5);
      rd(A_DONE, v); check("R8 done", v, 32'd5);
      rd(A_CUR, v);  check("R8 cur addr", v, 32'h0000_1248);
      check("R5 cs released", 32'(spi_cs_n), 32'd1);
      drain(5, 8'h00, 24'h001234, "R3 packed word");
      rd(A_STAT, v); check("R5 complete", v, 32'd2);

      // R4: empty read returns zero, no effect
      rd(A_DATA, v); check("R4 empty read", v, 32'd0);
      rd(A_LVL, v);  check("R4 level kept", v, 32'd0);

      // R6: stall when full
      wr(A_BASE, 32'h0004_0000);
      wr(A_NW, 32'd12);
      wr(A_CTRL, 32'd1);
      repeat (1500) @(posedge clk);
      rd(A_LVL, v);  check("R6 level full", v, 32'd8);
      rd(A_STAT, v); check("R6 still busy", v[0], 1'b1);
      e0 = sck_edges;
      repeat (200) @(posedge clk);
      check("R6 sck held", 32'(sck_edges - e0), 32'd0);
      check("R6 sck low", 32'(spi_sck), 32'd0);
      drain(12, 8'h00, 24'h040000, "R6 no loss");
      wait_idle();
      rd(A_STAT, v); check("R6 complete", v, 32'd2);

      // R7: 4-byte mode wrap inside the 16 MB window
      cfg_cmd = 8'h13; cfg_addr4 = 1'b1;
      n0 = cmd_log.size();
      wr(A_BASE, 32'h00FF_FFF8);
      wr(A_NW, 32'd4);
      wr(A_CTRL, 32'd1);
      wait_idle();
      check("R7 two commands", 32'(cmd_log.size() - n0), 32'd2);
      check("R2 4-byte addr", addr_log[n0], 32'h37FF_FFF8);
      check("R7 reissue addr", addr_log[n0 + 1], 32'h3700_0000);
      check("R7 reissue cmd", 32'(cmd_log[n0 + 1]), 32'h13);
      rd(A_CUR, v); check("R7 cur addr", v, 32'h3700_0008);
      drain(4, 8'h37, 24'hFFFFF8, "R7 wrapped data");

      // R9: zero count ignored
      cfg_addr4 = 1'b0; cfg_cmd = 8'h03;
      n0 = cmd_log.size();
      wr(A_NW, 32'd0);
      wr(A_CTRL, 32'd1);
      repeat (20) @(posedge clk);
      rd(A_STAT, v); check("R9 zero count idle", v, 32'd2);
      check("R9 zero count no cmd", 32'(cmd_log.size() - n0), 32'd0);

      // R9: start while busy ignored
      wr(A_BASE, 32'h0000_0100);
      wr(A_NW, 32'd3);
      wr(A_CTRL, 32'd1);
      wr(A_BASE, 32'h0000_0800);
      wr(A_CTRL, 32'd1);
      wait_idle();
      check("R9 busy start one cmd", 32'(cmd_log.size() - n0), 32'd1);
      check("R9 first addr kept", addr_log[n0], 32'h0000_0100);
      rd(A_DONE, v); check("R9 done count", v, 32'd3);
      drain(3, 8'h00, 24'h000100, "R9 data");
      rd(A_STAT, v); check("R5 final", v, 32'd2);

      summary();
   end
endmodule